// File: doc/BRIEF.md
# Code Overlay Loader Controller

This block keeps a small soft processor supplied with code overlays. The processor's program memory is a dual-port RAM. The processor fetches instructions through one port. This loader owns the other port and writes to it while the processor keeps running.

The upper half of the program address space is split into two overlay slots. When the kernel needs a subroutine, it places the subroutine number on an output register and raises a request bit. The loader then does the following:

- It fetches a two-word descriptor for that number from a backing code store: the image start address and the length in words.
- It copies the image word by word into the next slot in ping-pong order.
- It raises a ready bit.

The kernel reads the slot index to learn which base address to call. A load may optionally report ready early, once a chosen number of leading words is in place. A built-in sequencer walks an order table held in the backing store and shows the kernel which subroutine comes next.

The backing store is read one word at a time with a request pulse and a valid response of any latency.

Top module: `overlay_loader`

## Requirements
- R1: After a synchronous active-high reset, `svc_ready`, `load_err`, `cur_slot` and `pm_we` are 0, and the sequencer position is 0.
- R2: A load is accepted only after a rising edge of `svc_req`, and `sub_num` is captured at that point. Keeping `svc_req` high after ready causes no further store reads or program writes.
- R3: The descriptor for number N is read from store address `{2'b01, 1'b0, N, 1'b0}` (start, 18 bits) and `{2'b01, 1'b0, N, 1'b1}` (length). Word i of the image is read from start + i.
- R4: Each image word is written to the program memory in the same clock as its store valid response. The write address is 2^(PADDR_W-1) + slot·2^(PADDR_W-2) + i, and `pm_we` is never high outside such a response.
- R5: If the length is greater than the slot size (256 words by default), `load_err` rises together with `svc_ready` and nothing is written. The slot index and the sequencer are left unchanged. A length equal to the slot size is accepted. `load_err` clears when the next load is accepted.
- R6: `svc_ready` stays high while `svc_req` stays high, and it is low one clock after `svc_req` is low.
- R7: The first completed load after reset goes to slot 0, and successive completed loads alternate. `cur_slot` shows the slot of the most recently accepted load. A zero-length load completes at once and also counts as a completed load.
- R8: If `early_cnt` (captured with the request) is nonzero and less than the length, `svc_ready` rises one clock after word `early_cnt` is written, and the copy continues to the end. A value of 0 means ready comes after the last word.
- R9: `next_sub` shows the low 16 bits of the order-table entry at store address `{2'b10, pos}`. The position `pos` advances by one after each completed load and wraps.
- R10: At most one store read is outstanding, and `bs_req` is a single-cycle pulse per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_req | input | 1 | Load request bit from the processor |
| sub_num | input | 16 | Subroutine number to load |
| early_cnt | input | 9 | Leading-word count for early ready, 0 = off |
| svc_ready | output | 1 | Routine loaded, execution may continue |
| load_err | output | 1 | Last accepted load was rejected as too long |
| cur_slot | output | 1 | Slot targeted by the latest accepted load |
| next_sub | output | 16 | Next subroutine number from the sequencer |
| bs_req | output | 1 | Backing store read request pulse |
| bs_addr | output | 20 | Backing store read address |
| bs_rvalid | input | 1 | Backing store read data valid |
| bs_rdata | input | 18 | Backing store read data |
| pm_we | output | 1 | Program memory write-port write enable |
| pm_addr | output | 10 | Program memory write-port address |
| pm_wdata | output | 18 | Program memory write-port data |

## Verification
The hardest situation to reach is an early-ready load in which the processor drops its request while the copy is still running. Ready must fall, the remaining words must still be written, and the late completion must not raise ready again. The stimulus builds this case directly: it picks a leading-word count below the length, waits for ready, and lowers the request before the last word. The store answers with a latency drawn at random per read, so the point of the drop moves within the copy. A random run of loads with assorted lengths, numbers and early counts then repeats this alongside directed slot-size, oversize and zero-length loads.

// File: rtl/overlay_loader.sv
module overlay_loader #(
  parameter int PADDR_W = 10,
  parameter int IW      = 18,
  parameter int NUM_W   = 16,
  parameter int SAW     = 20,
  parameter int SEQ_W   = 4,
  parameter bit SEQ_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               svc_req,
  input  logic [NUM_W-1:0]   sub_num,
  input  logic [PADDR_W-2:0] early_cnt,
  output logic               svc_ready,
  output logic               load_err,
  output logic               cur_slot,
  output logic [NUM_W-1:0]   next_sub,
  output logic               bs_req,
  output logic [SAW-1:0]     bs_addr,
  input  logic               bs_rvalid,
  input  logic [IW-1:0]      bs_rdata,
  output logic               pm_we,
  output logic [PADDR_W-1:0] pm_addr,
  output logic [IW-1:0]      pm_wdata
);
  localparam int SLOT_AW    = PADDR_W - 2;
  localparam int SLOT_WORDS = 1 << SLOT_AW;
  localparam int LEN_W      = SLOT_AW + 1;
  localparam int DPAD       = SAW - NUM_W - 3;
  localparam int SPAD       = SAW - 2 - SEQ_W;

  typedef enum logic [2:0] {ST_SEQ, ST_IDLE, ST_DSTART, ST_DLEN, ST_COPY} st_t;

  st_t              state;
  logic             pend, req_q, armed, acked, slot_q, tgt, ready_q, err_q;
  logic [NUM_W-1:0] num_q, next_q;
  logic [LEN_W-1:0] early_q, len_q, wcnt;
  logic [SAW-1:0]   start_q;
  logic [SEQ_W-1:0] seq_pos;

  logic             rise, start, got, len_bad, len_zero, dlen_got;
  logic             err_hit, last, early_hit, done, ready_trig;
  logic [LEN_W-1:0] wnext;

  assign rise     = svc_req & ~req_q;
  assign start    = (state == ST_IDLE) & (armed | rise);
  assign got      = bs_rvalid & pend;
  assign wnext    = wcnt + LEN_W'(1);
  assign len_bad  = bs_rdata > IW'(SLOT_WORDS);
  assign len_zero = bs_rdata == '0;
  assign dlen_got = (state == ST_DLEN) & got;
  assign err_hit  = dlen_got & len_bad;
  assign last     = (state == ST_COPY) & got & (wnext == len_q);
  assign early_hit = (state == ST_COPY) & got & (early_q != '0) & (wnext == early_q);
  assign done     = last | (dlen_got & ~len_bad & len_zero);
  assign ready_trig = done | err_hit | early_hit;

  assign bs_req   = (state != ST_IDLE) & ~pend;
  always_comb begin
    unique case (state)
      ST_SEQ:    bs_addr = {2'b10, {SPAD{1'b0}}, seq_pos};
      ST_DSTART: bs_addr = {2'b01, {DPAD{1'b0}}, num_q, 1'b0};
      ST_DLEN:   bs_addr = {2'b01, {DPAD{1'b0}}, num_q, 1'b1};
      default:   bs_addr = start_q + SAW'(wcnt);
    endcase
  end

  assign pm_we     = (state == ST_COPY) & got;
  assign pm_addr   = {1'b1, tgt, wcnt[SLOT_AW-1:0]};
  assign pm_wdata  = bs_rdata;
  assign svc_ready = ready_q;
  assign load_err  = err_q;
  assign cur_slot  = tgt;
  assign next_sub  = SEQ_EN ? next_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_EN ? ST_SEQ : ST_IDLE;
      pend    <= 1'b0;
      req_q   <= 1'b0;
      armed   <= 1'b0;
      acked   <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      slot_q  <= 1'b0;
      tgt     <= 1'b0;
      seq_pos <= '0;
      next_q  <= '0;
      num_q   <= '0;
      early_q <= '0;
      len_q   <= '0;
      wcnt    <= '0;
      start_q <= '0;
    end else begin
      req_q <= svc_req;
      armed <= (armed | rise) & ~start;
      if (bs_req) pend <= 1'b1;
      else if (got) pend <= 1'b0;

      if (!svc_req) ready_q <= 1'b0;
      else if (ready_trig && !acked) ready_q <= 1'b1;

      if (start) acked <= 1'b0;
      else if (ready_trig) acked <= 1'b1;

      if (done) begin
        slot_q  <= ~slot_q;
        seq_pos <= seq_pos + SEQ_W'(1);
      end

      unique case (state)
        ST_SEQ: if (got) begin
          next_q <= bs_rdata[NUM_W-1:0];
          state  <= ST_IDLE;
        end
        ST_IDLE: if (start) begin
          num_q   <= sub_num;
          early_q <= early_cnt;
          tgt     <= slot_q;
          err_q   <= 1'b0;
          state   <= ST_DSTART;
        end
        ST_DSTART: if (got) begin
          start_q <= SAW'(bs_rdata);
          state   <= ST_DLEN;
        end
        ST_DLEN: if (got) begin
          if (len_bad) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end else if (len_zero) begin
            state <= SEQ_EN ? ST_SEQ : ST_IDLE;
          end else begin
            len_q <= bs_rdata[LEN_W-1:0];
            wcnt  <= '0;
            state <= ST_COPY;
          end
        end
        default: if (got) begin
          wcnt <= wnext;
          if (wnext == len_q) state <= SEQ_EN ? ST_SEQ : ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/overlay_loader_chk.sv
module overlay_loader_chk #(
  parameter int PADDR_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               svc_req,
  input logic               svc_ready,
  input logic               load_err,
  input logic               cur_slot,
  input logic               bs_req,
  input logic               bs_rvalid,
  input logic               pm_we,
  input logic [PADDR_W-1:0] pm_addr
);
  AST_WE_ON_VALID: assert property (@(posedge clk) disable iff (rst) pm_we |-> bs_rvalid); // R4
  AST_WE_UPPER_HALF: assert property (@(posedge clk) disable iff (rst) pm_we |-> pm_addr[PADDR_W-1]); // R4
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst) load_err |-> !pm_we); // R5
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst) !svc_req |=> !svc_ready); // R6
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst) (svc_ready && svc_req) |=> svc_ready); // R6
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (rst) svc_ready |=> $stable(cur_slot)); // R7
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst) bs_req |=> !bs_req); // R10
endmodule

bind overlay_loader overlay_loader_chk #(.PADDR_W(PADDR_W)) u_chk (
  .clk(clk), .rst(rst), .svc_req(svc_req), .svc_ready(svc_ready),
  .load_err(load_err), .cur_slot(cur_slot), .bs_req(bs_req),
  .bs_rvalid(bs_rvalid), .pm_we(pm_we), .pm_addr(pm_addr)
);

// File: tb/sim_overlay_loader.sv
module sim_overlay_loader;
  logic        clk = 1'b0, rst = 1'b1;
  logic        svc_req = 1'b0;
  logic [15:0] sub_num = '0;
  logic [8:0]  early_cnt = '0;
  logic        svc_ready, load_err, cur_slot, bs_req, pm_we;
  logic [15:0] next_sub;
  logic [19:0] bs_addr;
  logic        bs_rvalid = 1'b0;
  logic [17:0] bs_rdata = '0;
  logic [9:0]  pm_addr;
  logic [17:0] pm_wdata;

  overlay_loader u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, wr_cnt = 0, dbl_req = 0, seq_pos = 0, exp_slot = 0, lat = 0;
  bit finished = 0;
  logic [17:0] lens [16];
  logic [15:0] seqtab [16];
  logic [17:0] shadow [1024];
  logic        pend_m = 1'b0;
  logic [19:0] a_m = '0;

  function automatic logic [17:0] start_of(input logic [15:0] n);
    return 18'h00400 + 18'({n[7:0], 8'h00});
  endfunction
  function automatic logic [17:0] code_of(input logic [19:0] a);
    return a[17:0] ^ 18'h2B5C3;
  endfunction
  function automatic logic [17:0] mem(input logic [19:0] a);
    if (a[19:18] == 2'b01) return a[0] ? lens[a[4:1]] : start_of(a[16:1]);
    if (a[19:18] == 2'b10) return {2'b00, seqtab[a[3:0]]};
    return code_of(a);
  endfunction

  always @(posedge clk) begin
    bs_rvalid <= 1'b0;
    if (rst) pend_m <= 1'b0;
    else if (pend_m) begin
      if (bs_req) dbl_req <= dbl_req + 1;
      if (lat == 0) begin bs_rvalid <= 1'b1; bs_rdata <= mem(a_m); pend_m <= 1'b0; end
      else lat <= lat - 1;
    end else if (bs_req) begin
      pend_m <= 1'b1; a_m <= bs_addr; lat <= $urandom_range(0, 3);
    end
    if (!rst && pm_we) begin shadow[pm_addr] <= pm_wdata; wr_cnt <= wr_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp); end
  endtask

  task automatic wait_writes(input int target);
    for (int t = 0; t < 4000 && wr_cnt < target; t++) @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] num, input int len, input int early, input bit drop);
    int base, expc, bad, t;
    bit err;
    err = len > 256;
    lens[num[3:0]] = 18'(len);
    @(negedge clk);
    base = wr_cnt; sub_num = num; early_cnt = 9'(early); svc_req = 1'b1;
    for (t = 0; t < 4000 && !svc_ready; t++) @(negedge clk);
    chk(svc_ready, "R2", "ready after request", int'(svc_ready), 1);
    expc = err ? 0 : ((early != 0 && early < len) ? early : len);
    chk(wr_cnt - base == expc, (early != 0 && early < len) ? "R8" : "R4", "words at ready", wr_cnt - base, expc);
    chk(load_err == err, "R5", "error flag", int'(load_err), int'(err));
    chk(cur_slot == exp_slot[0], "R7", "slot index", int'(cur_slot), exp_slot);
    if (drop) begin
      svc_req = 1'b0;
      @(negedge clk);
      chk(!svc_ready, "R6", "ready low after early drop", int'(svc_ready), 0);
    end
    if (!err) wait_writes(base + len);
    repeat (12) @(negedge clk);
    if (!drop) begin
      chk(svc_ready, "R6", "ready held", int'(svc_ready), 1);
      chk(wr_cnt - base == (err ? 0 : len), "R2", "no rerun while held", wr_cnt - base, err ? 0 : len);
      svc_req = 1'b0;
      @(negedge clk);
      chk(!svc_ready, "R6", "ready low after drop", int'(svc_ready), 0);
    end else begin
      chk(!svc_ready, "R8", "late completion keeps ready low", int'(svc_ready), 0);
      chk(wr_cnt - base == len, "R8", "copy finished after drop", wr_cnt - base, len);
    end
    if (!err) begin
      bad = 0;
      for (int i = 0; i < len; i++)
        if (shadow[512 + exp_slot * 256 + i] !== code_of(20'(start_of(num)) + 20'(i))) bad++;
      chk(bad == 0, "R3", "image words in slot", bad, 0);
      exp_slot ^= 1;
      seq_pos = (seq_pos + 1) % 16;
    end
    repeat (10) @(negedge clk);
    chk(next_sub == seqtab[seq_pos], "R9", "next subroutine", next_sub, seqtab[seq_pos]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 16; i++) begin seqtab[i] = 16'h1000 + 16'(i * 16'h0111); lens[i] = 18'd4; end
    repeat (3) @(negedge clk);
    chk(!svc_ready && !load_err && !cur_slot && !pm_we, "R1", "outputs in reset",
        {svc_ready, load_err, cur_slot, pm_we}, 0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(next_sub == seqtab[0], "R1", "sequencer at position 0", next_sub, seqtab[0]);
    chk(wr_cnt == 0, "R1", "no writes after reset", wr_cnt, 0);
    repeat (10) @(negedge clk);
    chk(wr_cnt == 0, "R2", "no load without request", wr_cnt, 0);

    do_load(16'h0003, 5, 0, 0);
    do_load(16'hABC7, 256, 0, 0);
    do_load(16'h0009, 300, 0, 0);
    do_load(16'h0005, 0, 0, 0);
    do_load(16'h0022, 30, 8, 0);
    do_load(16'h0041, 40, 6, 1);
    do_load(16'h0011, 1, 1, 0);

    for (int k = 0; k < 10; k++) begin
      int len, early;
      logic [15:0] num;
      num = 16'($urandom);
      len = $urandom_range(1, 48);
      early = ($urandom_range(0, 2) == 0) ? $urandom_range(1, len) : 0;
      do_load(num, len, early, (early != 0 && early < len) ? 1'($urandom_range(0, 1)) : 1'b0);
    end
    chk(dbl_req == 0, "R10", "requests while read pending", dbl_req, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule